// File: doc/BRIEF.md
# Signed Word Right-Shift Unit

This unit executes a 32-bit arithmetic right shift as one pipeline stage of a fixed-point execution path. It takes a 64-bit source operand, a 64-bit count operand, a record flag and the current sticky summary-overflow bit. One clock after a valid strobe, it returns three things:

- a 64-bit result, which is the shifted low word sign-extended to 64 bits;
- the carry bit for the fixed-point exception register;
- when the record flag is set, a write-enabled 4-bit condition field.

Counts from 32 to 63 saturate to the sign of the source word. The carry tells software whether a negative value lost any one bits. A following add-of-carry then rounds a signed divide by a power of two toward zero.

Only the low six count bits take part. The upper 32 source bits never influence the outcome. The unit does not touch overflow or summary-overflow state. It only reads the summary bit to copy it into the condition field.

Top module: `sraw_unit`

## Requirements
- R1: The shift count is `amt_val[5:0]`; bits 63..6 of `amt_val` have no effect on any output.
- R2: Only `src_val[31:0]` is shifted, arithmetically (vacated bits take `src_val[31]`); `src_val[63:32]` has no effect on any output.
- R3: `result[63:32]` always equals 32 copies of `result[31]`.
- R4: For counts 32..63 the result is all ones when `src_val[31]` is 1 and all zeros otherwise, and `carry_out` equals `src_val[31]`.
- R5: For counts 1..31 `carry_out` is 1 exactly when `src_val[31]` is 1 and at least one of the `count` lowest bits of `src_val[31:0]` is 1.
- R6: A count of 0 returns `src_val[31:0]` sign-extended to 64 bits with `carry_out` 0.
- R7: `carry_out` is produced for every operation, whatever the value of `rec_flag`.
- R8: With `rec_flag` = 1, `cond_we` is 1 and `cond_field` is {LT, GT, EQ, SO} in bits 3..0, where LT/GT/EQ come from a signed compare of `result` with zero and SO copies `so_in`.
- R9: With `rec_flag` = 0, `cond_we` is 0 and `cond_field` is 4'b0000.
- R10: Outputs update one cycle after `in_valid`, and `out_valid` is then 1 for exactly that cycle. With `in_valid` low, `out_valid` is 0 and the data outputs hold their last values.
- R11: A synchronous active-high `rst` clears `out_valid`, `result`, `carry_out`, `cond_we` and `cond_field` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_val | input | 64 | Source operand; low word is shifted |
| amt_val | input | 64 | Count operand; low six bits used |
| rec_flag | input | 1 | Record flag, requests condition update |
| so_in | input | 1 | Current sticky summary-overflow bit |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 64 | Sign-extended shifted word |
| carry_out | output | 1 | Carry bit for the exception register |
| cond_we | output | 1 | Condition field write enable |
| cond_field | output | 4 | {LT, GT, EQ, SO} |

## Verification
The vectors cover the following cases:

- Negative and positive source words at small, mid and maximum in-range counts. These separate a carry caused by shifted-out ones from one wrongly caused by the sign bit alone. One negative word has only zeros below the cut, so no carry is expected there.
- Counts of exactly 31, 32 and 63. These tell correct saturation apart from a shifter that wraps the count modulo 32.
- A count of zero with a negative source. This confirms carry is forced low even though the sign bit is set.
- Junk in the upper operand halves. This exposes a design that reads the wrong bits.
- Record-flag variants with the summary bit set and clear, giving negative, positive and zero results. These check each compare bit and the copied summary bit on its own.

// File: rtl/sraw_pkg.sv
package sraw_pkg;

  // Condition field layout, bit 3 down to bit 0.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  localparam cond_t COND_NONE = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, so: 1'b0};

  function automatic cond_t make_cond(input logic neg, input logic zero, input logic so);
    cond_t c;
    c.lt = neg;
    c.gt = !neg && !zero;
    c.eq = zero;
    c.so = so;
    return c;
  endfunction

endpackage

// File: rtl/sraw_shift_core.sv
module sraw_shift_core #(
  parameter int XLEN  = 64,
  parameter int WLEN  = 32,
  parameter int CNT_W = 6
) (
  input  logic [WLEN-1:0]  word_in,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_big,
  output logic [XLEN-1:0]  shifted
);
  localparam int SH_W = $clog2(WLEN);
  localparam int EXT_W = XLEN - WLEN;

  function automatic logic [WLEN-1:0] asr_word(input logic [WLEN-1:0] w, input logic [SH_W-1:0] n);
    return WLEN'($signed(w) >>> n);
  endfunction

  function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
    return {{EXT_W{w[WLEN-1]}}, w};
  endfunction

  logic [WLEN-1:0] in_range_w;
  logic [WLEN-1:0] sat_w;
  logic [WLEN-1:0] word_res;

  assign cnt_big    = (cnt >= CNT_W'(WLEN));
  assign in_range_w = asr_word(word_in, cnt[SH_W-1:0]);
  assign sat_w      = {WLEN{word_in[WLEN-1]}};
  assign word_res   = cnt_big ? sat_w : in_range_w;
  assign shifted    = sext_word(word_res);

endmodule

// File: rtl/sraw_carry_gen.sv
module sraw_carry_gen #(
  parameter int WLEN  = 32,
  parameter int CNT_W = 6
) (
  input  logic [WLEN-1:0]  word_in,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_big,
  output logic             lost_ones,
  output logic             carry
);
  localparam int SH_W = $clog2(WLEN);

  // Mask of the n lowest bits, built from the count alone.
  function automatic logic [WLEN-1:0] low_mask(input logic [SH_W-1:0] n);
    return ~({WLEN{1'b1}} << n);
  endfunction

  logic [WLEN-1:0] mask_w;

  assign mask_w    = low_mask(cnt[SH_W-1:0]);
  assign lost_ones = cnt_big ? (|word_in) : (|(word_in & mask_w));
  assign carry     = word_in[WLEN-1] && (cnt_big || lost_ones);

endmodule

// File: rtl/sraw_cond_gen.sv
module sraw_cond_gen
  import sraw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] res,
  input  logic            rec,
  input  logic            so,
  output cond_t           cond
);
  logic neg_w;
  logic zero_w;

  assign neg_w  = res[XLEN-1];
  assign zero_w = (res == '0);
  assign cond   = rec ? make_cond(neg_w, zero_w, so) : COND_NONE;

endmodule

// File: rtl/sraw_unit.sv
module sraw_unit
  import sraw_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int WLEN  = 32,
  parameter int CNT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] amt_val,
  input  logic            rec_flag,
  input  logic            so_in,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            carry_out,
  output logic            cond_we,
  output logic [3:0]      cond_field
);
  localparam int EXT_W = XLEN - WLEN;

  logic [WLEN-1:0]  word_w;
  logic [CNT_W-1:0] cnt_w;
  logic             cnt_big_w;
  logic             lost_ones_w;
  logic             carry_w;
  logic [XLEN-1:0]  shifted_w;
  cond_t            cond_w;
  logic             unused_hi_w;

  assign word_w      = src_val[WLEN-1:0];
  assign cnt_w       = amt_val[CNT_W-1:0];
  assign unused_hi_w = ^{amt_val[XLEN-1:CNT_W], src_val[XLEN-1:WLEN]};

  sraw_shift_core #(.XLEN(XLEN), .WLEN(WLEN), .CNT_W(CNT_W)) u_shift (
    .word_in (word_w),
    .cnt     (cnt_w),
    .cnt_big (cnt_big_w),
    .shifted (shifted_w)
  );

  sraw_carry_gen #(.WLEN(WLEN), .CNT_W(CNT_W)) u_carry (
    .word_in   (word_w),
    .cnt       (cnt_w),
    .cnt_big   (cnt_big_w),
    .lost_ones (lost_ones_w),
    .carry     (carry_w)
  );

  sraw_cond_gen #(.XLEN(XLEN)) u_cond (
    .res  (shifted_w),
    .rec  (rec_flag),
    .so   (so_in),
    .cond (cond_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      carry_out  <= 1'b0;
      cond_we    <= 1'b0;
      cond_field <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= shifted_w;
        carry_out  <= carry_w;
        cond_we    <= rec_flag;
        cond_field <= cond_w;
      end
    end
  end

  // R3: upper half mirrors the word sign
  p_upper_sext_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result[XLEN-1:WLEN] == {EXT_W{result[WLEN-1]}}));

  // R4: saturating counts fill with the source sign
  p_sat_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_big_w) |=> (result == {XLEN{$past(src_val[WLEN-1])}})
                                 && (carry_out == $past(src_val[WLEN-1])));

  // R5: carry only from a negative word that lost a one bit
  p_carry_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cnt_big_w && !lost_ones_w) |=> !carry_out);

  // R6: zero count never yields carry
  p_zero_cnt_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_w == '0) |=> (!carry_out && result[WLEN-1:0] == $past(src_val[WLEN-1:0])));

  // R8: exactly one compare bit when recording
  p_cond_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cond_we) |-> ($countones(cond_field[3:1]) == 1));

  // R9: no record, no condition bits
  p_cond_off_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cond_we) |-> (cond_field == 4'b0000));

  // R10: one-cycle strobe and hold
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out)));

endmodule

// File: tb/sraw_unit_bench.sv
`timescale 1ns/1ps
module sraw_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] src_val;
  logic [63:0] amt_val;
  logic        rec_flag;
  logic        so_in;
  logic        out_valid;
  logic [63:0] result;
  logic        carry_out;
  logic        cond_we;
  logic [3:0]  cond_field;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  sraw_unit u_sraw_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_val(src_val),
    .amt_val(amt_val), .rec_flag(rec_flag), .so_in(so_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .cond_we(cond_we), .cond_field(cond_field)
  );

  localparam int NV = 13;
  localparam logic [63:0] V_SRC [NV] = '{
    64'h0000_0000_8000_0000, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_FFFF,
    64'hFFFF_FFFF_0000_0010, 64'h0000_0000_FFFF_FFF1, 64'h0000_0000_8000_0000,
    64'h0000_0000_8000_0000, 64'h0000_0000_1234_5678, 64'hDEAD_BEEF_1234_5678,
    64'h0000_0000_8765_4321, 64'h0000_0000_8765_4321, 64'h0000_0000_FFFF_FFFF,
    64'h0000_0000_0000_0001};
  localparam logic [63:0] V_AMT [NV] = '{
    64'd4, 64'd1, 64'd4, 64'hFFFF_FFFF_FFFF_FFC4, 64'd31, 64'd31,
    64'd32, 64'd63, 64'd0, 64'd0, 64'd8, 64'd40, 64'd1};
  localparam logic [63:0] V_RES [NV] = '{
    64'hFFFF_FFFF_F800_0000, 64'hFFFF_FFFF_C000_0000, 64'h0000_0000_07FF_FFFF,
    64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_1234_5678,
    64'hFFFF_FFFF_8765_4321, 64'hFFFF_FFFF_FF87_6543, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0000};
  localparam bit V_CA  [NV] = '{0, 1, 0, 0, 1, 0, 1, 0, 0, 0, 1, 1, 0};
  localparam bit V_REC [NV] = '{0, 1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 0, 1};
  localparam bit V_SO  [NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 0, 1, 1, 0, 0};
  localparam string V_TAG [NV] = '{
    "R5", "R5", "R2", "R1", "R5", "R5", "R4", "R4", "R2", "R6", "R5", "R4", "R5"};

  // Condition expected from the requirement text: {LT,GT,EQ,SO}.
  function automatic logic [3:0] want_cond(input logic [63:0] r, input bit rec, input bit so);
    if (!rec) return 4'b0000;
    if ($signed(r) < 0) return {3'b100, so};
    if (r == 64'd0)     return {3'b001, so};
    return {3'b010, so};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] s, input logic [63:0] a, input bit rec, input bit so);
    @(negedge clk);
    src_val = s; amt_val = a; rec_flag = rec; so_in = so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] keep_res;
    rst = 1'b1; in_valid = 1'b0; src_val = '0; amt_val = '0; rec_flag = 1'b0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11", "out_valid", {63'd0, out_valid}, 64'd0);
    check("R11", "result", result, 64'd0);
    check("R11", "carry", {63'd0, carry_out}, 64'd0);
    check("R11", "cond", {59'd0, cond_we, cond_field}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(V_SRC[i], V_AMT[i], V_REC[i], V_SO[i]);
      check("R10", "out_valid", {63'd0, out_valid}, 64'd1);
      check(V_TAG[i], "result", result, V_RES[i]);
      check(V_REC[i] ? V_TAG[i] : "R7", "carry", {63'd0, carry_out}, {63'd0, V_CA[i]});
      check("R3", "upper", {32'd0, result[63:32]}, {32'd0, {32{V_RES[i][31]}}});
      check(V_REC[i] ? "R8" : "R9", "cond_we", {63'd0, cond_we}, {63'd0, V_REC[i]});
      check(V_REC[i] ? "R8" : "R9", "cond_field", {60'd0, cond_field},
            {60'd0, want_cond(V_RES[i], V_REC[i], V_SO[i])});
    end

    // R10: inputs change without strobe, outputs hold
    keep_res = result;
    @(negedge clk);
    src_val = 64'h0000_0000_8000_0000; amt_val = 64'd3; rec_flag = 1'b1;
    @(negedge clk);
    check("R10", "hold out_valid", {63'd0, out_valid}, 64'd0);
    check("R10", "hold result", result, keep_res);

    // R6: negative source, zero count with upper count junk also zero in low six
    issue(64'h1111_1111_F000_000F, 64'hABCD_0000_0000_0040, 1'b1, 1'b0);
    check("R6", "zero count result", result, 64'hFFFF_FFFF_F000_000F);
    check("R6", "zero count carry", {63'd0, carry_out}, 64'd0);
    check("R8", "zero count cond", {60'd0, cond_field}, 64'h8);

    // R7: same stimulus, record off, carry still produced
    issue(64'h0000_0000_F000_000F, 64'd2, 1'b0, 1'b1);
    check("R7", "carry without record", {63'd0, carry_out}, 64'd1);
    check("R9", "cond off", {59'd0, cond_we, cond_field}, 64'd0);

    // R11: reset mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "rst result", result, 64'd0);
    check("R11", "rst carry", {63'd0, carry_out}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule